// File: doc/BRIEF.md
# FIFO-level ready flag generator

This block turns the occupancy of one serial channel's receive and transmit FIFOs into two status bits. The bits say whether that direction wants service. The transmit bit is high while enough FIFO slots are free. The receive bit is high while enough characters are waiting, or while an enabled receive watchdog has expired. A mask and arbiter outside the block consume both bits. Each direction has its own 2-bit threshold.

Every access to a FIFO pulls its bit low: a write for the transmit side, a read for the receive side. The bit is then held low for a short blanking window. This gives the servicing agent time to see the bit drop before the block judges the threshold again.

The receive side has one exception. When the threshold is the full depth, the FIFO is full and a character sits in the shift register, a read still clears the bit. The bit then comes back on the first clock at which the FIFO is full again, without waiting out the blanking window.

Top module: `fifo_ready_flags`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, both `tx_rdy` and `rx_rdy` are 0.
- R2: The threshold codes are 0, 1, 2 and 3. They select levels of 1, DEPTH/2, 3*DEPTH/4 and DEPTH entries (1, 4, 6 and 8 for DEPTH=8). With no write blanking active, `tx_rdy` takes the value of (`tx_en` and DEPTH-`tx_cnt` >= level(`tx_lvl_sel`)) at each rising clock edge.
- R3: When `tx_en` is low at a clock edge, `tx_rdy` is 0 after that edge. When `tx_en` goes high with `tx_cnt`=0, `tx_rdy` is 1 after the first clock edge.
- R4: A clock edge at which `tx_wr` is high makes `tx_rdy` 0, and so does the following edge. At the second edge after the strobe, `tx_rdy` again follows R2. A new strobe restarts this window.
- R5: With no read blanking active, `rx_rdy` takes the value of (`rx_cnt` >= level(`rx_lvl_sel`)), or of the watchdog term of R6, at each rising clock edge. The levels are those listed in R2.
- R6: With `wdog_en` high, a high `wdog_to` makes `rx_rdy` 1 whatever the fill level. With `wdog_en` low, `wdog_to` has no effect on `rx_rdy`.
- R7: A clock edge at which `rx_rd` is high makes `rx_rdy` 0, and so does the following edge. At the second edge after the strobe, `rx_rdy` again follows R5. A new strobe restarts this window.
- R8: This case applies when, at the edge of a read, `rx_lvl_sel`=3, `rx_cnt`=DEPTH and `rx_shift_pend`=1. `rx_rdy` goes 0 after that read edge. If the R5 condition holds at the next edge, `rx_rdy` is 1 after that edge, which skips the second blanked cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enabled; low also covers transmitter reset |
| tx_wr | input | 1 | Write strobe into the transmit FIFO |
| tx_cnt | input | CNT_W | Entries held in the transmit FIFO (0..DEPTH) |
| tx_lvl_sel | input | 2 | Transmit empty-slot threshold code |
| rx_rd | input | 1 | Read strobe from the receive FIFO |
| rx_cnt | input | CNT_W | Entries held in the receive FIFO (0..DEPTH) |
| rx_lvl_sel | input | 2 | Receive fill threshold code |
| rx_shift_pend | input | 1 | A received character waits in the shift register |
| wdog_en | input | 1 | Receive watchdog enabled |
| wdog_to | input | 1 | Receive watchdog timed out |
| tx_rdy | output | 1 | Transmit-ready status bit |
| rx_rdy | output | 1 | Receive-ready status bit |

## Verification
An access strobe can land in the same cycle as a threshold crossing or a watchdog timeout. In that case the clear must win, and the blanking window must still hide the condition for one more clock. Random traffic with strobes at a quarter duty cycle, random counts and random codes provokes this overlap often. Directed sequences place a read on a full FIFO with a pending character, and a read during a watchdog timeout. A cycle model built from the requirements judges every output sample.

// File: rtl/frf_pkg.sv
package frf_pkg;

  typedef enum logic [1:0] {
    LVL_ONE  = 2'd0,
    LVL_HALF = 2'd1,
    LVL_3Q   = 2'd2,
    LVL_FULL = 2'd3
  } lvl_code_e;

  function automatic int unsigned frf_level(input lvl_code_e code, input int unsigned depth);
    case (code)
      LVL_ONE:  return 1;
      LVL_HALF: return depth / 2;
      LVL_3Q:   return (depth * 3) / 4;
      default:  return depth;
    endcase
  endfunction

endpackage

// File: rtl/frf_thresh.sv
module frf_thresh
  import frf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             meets
);

  localparam int unsigned NLVL = 4;

  logic [CNT_W-1:0] lvl_tab [NLVL];
  logic [CNT_W-1:0] lvl_sel_val;

  // Level table computed from the depth, one entry per code.
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_tab[g] = CNT_W'(frf_level(lvl_code_e'(g), DEPTH));
  end

  always_comb begin
    lvl_sel_val = lvl_tab[sel];
    meets       = (cnt >= lvl_sel_val);
  end

endmodule

// File: rtl/frf_blank.sv
module frf_blank #(
  parameter int unsigned BLANK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic busy
);

  localparam int unsigned BW = $clog2(BLANK + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK - 1);

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = strobe || busy;
    cnt_d  = strobe ? LOAD : (cnt_q - BW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: the window counter never holds more than the load value.
  p_blank_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

endmodule

// File: rtl/frf_flag.sv
module frf_flag #(
  parameter int unsigned BLANK = 2,
  parameter bit          FAST  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cond,
  input  logic fast_arm,
  output logic flag
);

  logic busy;
  logic bypass;
  logic flag_q;
  logic flag_d;

  frf_blank #(.BLANK(BLANK)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .busy  (busy)
  );

  if (FAST) begin : g_fast
    logic armed_q;
    logic armed_d;
    logic armed_en;

    always_comb begin
      armed_en = strobe || armed_q;
      armed_d  = strobe ? fast_arm : (armed_q && busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b0;
      end else if (armed_en) begin
        armed_q <= armed_d;
      end
    end

    assign bypass = armed_q;

    // R8: an armed window lets a met condition through on the next edge.
    p_fast_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && busy && cond && !strobe) |=> flag);
  end else begin : g_plain
    logic unused_fast;
    assign unused_fast = fast_arm;
    assign bypass      = 1'b0;
  end

  always_comb begin
    flag_d = !strobe && cond && (!busy || bypass);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R4 and R7: an access strobe always drops the flag at the next edge.
  p_drop_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !flag);

  // R4: without bypass, the edge after a strobe edge still blanks.
  p_blank_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bypass) |=> !flag);

endmodule

// File: rtl/fifo_ready_flags.sv
module fifo_ready_flags
  import frf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned BLANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_wr,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [1:0]       tx_lvl_sel,
  input  logic             rx_rd,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [1:0]       rx_lvl_sel,
  input  logic             rx_shift_pend,
  input  logic             wdog_en,
  input  logic             wdog_to,
  output logic             tx_rdy,
  output logic             rx_rdy
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] tx_empty;
  logic             tx_meets;
  logic             rx_meets;
  logic             tx_cond;
  logic             rx_cond;
  logic             rx_fast;

  always_comb begin
    tx_empty = FULL_CNT - tx_cnt;
  end

  frf_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_thr (
    .sel  (tx_lvl_sel),
    .cnt  (tx_empty),
    .meets(tx_meets)
  );

  frf_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_thr (
    .sel  (rx_lvl_sel),
    .cnt  (rx_cnt),
    .meets(rx_meets)
  );

  always_comb begin
    tx_cond = tx_en && tx_meets;
    rx_cond = rx_meets || (wdog_en && wdog_to);
    rx_fast = (lvl_code_e'(rx_lvl_sel) == LVL_FULL) && (rx_cnt == FULL_CNT) && rx_shift_pend;
  end

  frf_flag #(.BLANK(BLANK), .FAST(1'b0)) u_tx_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (tx_wr),
    .cond    (tx_cond),
    .fast_arm(1'b0),
    .flag    (tx_rdy)
  );

  frf_flag #(.BLANK(BLANK), .FAST(1'b1)) u_rx_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (rx_rd),
    .cond    (rx_cond),
    .fast_arm(rx_fast),
    .flag    (rx_rdy)
  );

  // R3: a disabled transmitter never shows ready.
  p_tx_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_rdy);

  // R2: a rising transmit flag follows an enabled, met threshold.
  p_tx_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(tx_en && tx_meets));

  // R6: a rising receive flag needs the level or an enabled timeout.
  p_rx_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(rx_meets || (wdog_en && wdog_to)));

  // R7: a read strobe clears the receive flag.
  p_rx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !rx_rdy);

endmodule

// File: tb/tb_fifo_ready_flags.sv
module tb_fifo_ready_flags;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic             tx_en, tx_wr, rx_rd, rx_shift_pend, wdog_en, wdog_to;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [1:0]       tx_lvl_sel, rx_lvl_sel;
  logic             tx_rdy, rx_rdy;

  int    n_tests;
  int    n_fail;
  int    cyc;
  string cur_req;

  // Expected-state model
  logic m_tx, m_rx, m_arm;
  int   m_txb, m_rxb;

  fifo_ready_flags #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_wr(tx_wr), .tx_cnt(tx_cnt),
    .tx_lvl_sel(tx_lvl_sel), .rx_rd(rx_rd), .rx_cnt(rx_cnt), .rx_lvl_sel(rx_lvl_sel),
    .rx_shift_pend(rx_shift_pend), .wdog_en(wdog_en), .wdog_to(wdog_to),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0:    return 1;
      2'd1:    return DEPTH / 2;
      2'd2:    return (DEPTH * 3) / 4;
      default: return DEPTH;
    endcase
  endfunction

  function automatic logic tx_ok(input logic en, input logic [CNT_W-1:0] c, input logic [1:0] s);
    return en && ((int'(DEPTH) - int'(c)) >= lvl(s));
  endfunction

  function automatic logic rx_ok(input logic [CNT_W-1:0] c, input logic [1:0] s,
                                 input logic we, input logic wt);
    return (int'(c) >= lvl(s)) || (we && wt);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 1'b0; m_rx = 1'b0; m_arm = 1'b0; m_txb = 0; m_rxb = 0;
    end else begin
      if (tx_wr) begin
        m_tx = 1'b0; m_txb = 1;
      end else if (m_txb > 0) begin
        m_tx = 1'b0; m_txb = m_txb - 1;
      end else begin
        m_tx = tx_ok(tx_en, tx_cnt, tx_lvl_sel);
      end
      if (rx_rd) begin
        m_rx = 1'b0; m_rxb = 1;
        m_arm = (rx_lvl_sel == 2'd3) && (int'(rx_cnt) == DEPTH) && rx_shift_pend;
      end else if (m_rxb > 0) begin
        m_rx = m_arm ? rx_ok(rx_cnt, rx_lvl_sel, wdog_en, wdog_to) : 1'b0;
        m_rxb = m_rxb - 1; m_arm = 1'b0;
      end else begin
        m_rx = rx_ok(rx_cnt, rx_lvl_sel, wdog_en, wdog_to);
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 200000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check_out();
    n_tests = n_tests + 1;
    if (tx_rdy !== m_tx || rx_rdy !== m_rx) begin
      n_fail = n_fail + 1;
      $display("FAIL %s cycle %0d: actual tx_rdy=%b rx_rdy=%b, expected tx_rdy=%b rx_rdy=%b",
               cur_req, cyc, tx_rdy, rx_rdy, m_tx, m_rx);
    end
  endtask

  task automatic idle_in();
    tx_wr = 1'b0; rx_rd = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_out();
      idle_in();
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0;
    cur_req = "R1";
    rst_n = 1'b0;
    tx_en = 1'b0; tx_wr = 1'b0; tx_cnt = '0; tx_lvl_sel = 2'd0;
    rx_rd = 1'b0; rx_cnt = '0; rx_lvl_sel = 2'd0; rx_shift_pend = 1'b0;
    wdog_en = 1'b0; wdog_to = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R3: enable with an empty FIFO, then disable
    cur_req = "R3";
    tx_en = 1'b1; tx_cnt = '0;
    step(2);
    tx_en = 1'b0;
    step(2);
    tx_en = 1'b1;

    // R2: each code at the boundary and one slot short
    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      tx_lvl_sel = 2'(c);
      tx_cnt = CNT_W'(DEPTH - lvl(2'(c)));
      step(2);
      tx_cnt = CNT_W'(DEPTH - lvl(2'(c)) + 1);
      step(2);
    end

    // R4: single and back-to-back writes while the condition holds
    cur_req = "R4";
    tx_lvl_sel = 2'd0; tx_cnt = '0;
    step(2);
    tx_wr = 1'b1; step(1);
    step(3);
    tx_wr = 1'b1; step(1);
    tx_wr = 1'b1; step(1);
    step(3);

    // R5: receive codes at the boundary and one short
    cur_req = "R5";
    for (int c = 0; c < 4; c++) begin
      rx_lvl_sel = 2'(c);
      rx_cnt = CNT_W'(lvl(2'(c)));
      step(2);
      rx_cnt = CNT_W'(lvl(2'(c)) - 1);
      step(2);
    end

    // R6: timeout ignored when disabled, honoured when enabled
    cur_req = "R6";
    rx_lvl_sel = 2'd3; rx_cnt = CNT_W'(2);
    wdog_to = 1'b1; wdog_en = 1'b0;
    step(2);
    wdog_en = 1'b1;
    step(2);
    rx_rd = 1'b1; step(1);
    step(3);
    wdog_en = 1'b0; wdog_to = 1'b0;
    step(2);

    // R7: read at a held level, then read that drops below the level
    cur_req = "R7";
    rx_lvl_sel = 2'd1; rx_cnt = CNT_W'(6);
    step(2);
    rx_rd = 1'b1; step(1);
    step(3);
    rx_rd = 1'b1; rx_cnt = CNT_W'(4); step(1);
    rx_cnt = CNT_W'(3);
    step(3);

    // R8: full FIFO, level 8, pending character refills at once
    cur_req = "R8";
    rx_lvl_sel = 2'd3; rx_cnt = CNT_W'(DEPTH); rx_shift_pend = 1'b1;
    step(2);
    rx_rd = 1'b1; step(1);
    rx_shift_pend = 1'b0;
    step(3);
    // same read without a pending character keeps full blanking
    rx_rd = 1'b1; step(1);
    step(3);
    // pending character arrives one cycle late: normal reassert
    rx_shift_pend = 1'b1;
    step(1);
    rx_rd = 1'b1; step(1);
    rx_cnt = CNT_W'(DEPTH - 1); step(1);
    rx_cnt = CNT_W'(DEPTH); rx_shift_pend = 1'b0;
    step(3);

    // Random mix covering every requirement against the model
    cur_req = "R2/R4/R5/R6/R7/R8";
    void'($urandom(32'd20240517));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check_out();
      tx_en         = ($urandom % 8) != 0;
      tx_wr         = ($urandom % 4) == 0;
      rx_rd         = ($urandom % 4) == 0;
      tx_cnt        = CNT_W'($urandom % (DEPTH + 1));
      rx_cnt        = (($urandom % 3) == 0) ? CNT_W'(DEPTH) : CNT_W'($urandom % (DEPTH + 1));
      rx_shift_pend = ($urandom % 2) == 0;
      wdog_en       = ($urandom % 2) == 0;
      wdog_to       = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) tx_lvl_sel = 2'($urandom % 4);
      if (($urandom % 16) == 0) rx_lvl_sel = 2'($urandom % 4);
    end
    step(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule